// File: doc/BRIEF.md
# Serial EEPROM Transaction Controller

This block is the only master on a two-wire open-drain serial bus. It runs one complete transaction against a memory-style slave that has an 8-bit internal address. A one-cycle `go` strobe starts the transaction. At that strobe the block captures the direction, the internal address and the write byte. A write sends the slave address with the write flag, the internal address and the data byte. A read first sends the internal address as a dummy write. It then issues a repeated START, sends the slave address with the read flag, receives one byte, answers it with NACK and closes the bus.

The block never drives either line high. `scl_drv_low` and `sda_drv_low` are pull-down enables. `sda_in` is the line as the external pull-up leaves it. Every SCL period is 4·QDIV system clocks, split into four equal quarters. SCL goes low at the start of quarter 0. SDA takes its new value at the start of quarter 1. SCL is released at the start of quarter 2. The line is sampled at the start of quarter 3, the middle of the high half. If the slave NACKs a transmitted byte, the block sends that byte again. After MAX_TRIES refusals of the same byte it gives up, closes the bus and raises a sticky error flag.

Top module: `i2c_eeprom_master`

## Requirements
- R1: During data and acknowledge bits, SDA changes only while SCL is low and holds its level over the whole high half. The two drive enables never toggle in the same system clock.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A write has exactly one START and one STOP. A read has two STARTs and one STOP. Both lines are released while idle.
- R3: An address byte is DEV_ADDR in bits 7..1, sent MSB first, with bit 0 = 0 for write and 1 for read. With the default DEV_ADDR of 7'b1010000 these bytes are 0xA0 and 0xA1.
- R4: A write sends the address byte with the write flag, then the internal address, then the data byte. The slave location then holds the data byte.
- R5: A read does the dummy write and the repeated START, then receives 8 bits MSB first into `rd_data`. The master leaves SDA high (NACK) on the ninth clock.
- R6: A byte answered with NACK (SDA high on the ninth clock) is sent again unchanged, with no new START. A byte refused MAX_TRIES-1 times and then accepted lets the transaction complete without error.
- R7: When one byte is refused MAX_TRIES (default 3) times, the block stops sending and issues STOP. It then pulses `done` with `err` high. A write that fails this way leaves the slave location unchanged.
- R8: `err` stays set until the next accepted `go` clears it.
- R9: A `go` strobe that arrives while a transaction is running is ignored. No second transaction follows and its inputs are not used.
- R10: `done` is high for exactly one system clock, after STOP completes, with both lines released.
- R11: With QDIV=4, SCL rises every 16 system clocks inside a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, used only while idle |
| rd | input | 1 | 1 = random read, 0 = byte write |
| reg_addr | input | 8 | Internal address in the slave |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte from the last read |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Sticky retry-limit flag |
| scl_drv_low | output | 1 | Pull SCL low when 1 |
| sda_drv_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The assertions assume QDIV is at least 2, so the clock after SCL is released is never a sampling or START/STOP quarter. They also assume `go` is a level seen on system clock edges, with no meaning outside the idle state. The bench keeps QDIV at its default of 4. It drives `go` for exactly one clock from the falling clock edge, with random direction, internal address and data, and it deliberately raises `go` once in the middle of a transaction. The bench slave changes SDA only on SCL falling edges, so the acknowledge level that the master samples is already settled.

// File: rtl/i2c_eeprom_master.sv
module i2c_eeprom_master #(
  parameter int QDIV = 4,
  parameter logic [6:0] DEV_ADDR = 7'b1010000,
  parameter int MAX_TRIES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       rd,
  input  logic [7:0] reg_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       done,
  output logic       err,
  output logic       scl_drv_low,
  output logic       sda_drv_low,
  input  logic       sda_in
);
  localparam int DW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [DW-1:0] DLAST = DW'(QDIV - 1);
  localparam logic [TW-1:0] TLAST = TW'(MAX_TRIES - 1);

  typedef enum logic [1:0] {SY_IDLE, SY_START, SY_BIT, SY_STOP} sym_t;
  typedef enum logic [2:0] {PH_AW, PH_REG, PH_DAT, PH_AR, PH_RX} ph_t;

  sym_t          sym;
  ph_t           ph;
  logic [DW-1:0] dcnt;
  logic [1:0]    q;
  logic [3:0]    bcnt;
  logic [TW-1:0] tries;
  logic [7:0]    sh, ra_l, wd_l, txb;
  logic          rd_l, ack_ok;

  always_comb begin
    unique case (ph)
      PH_AW:   txb = {DEV_ADDR, 1'b0};
      PH_REG:  txb = ra_l;
      PH_DAT:  txb = wd_l;
      default: txb = {DEV_ADDR, 1'b1};
    endcase
  end

  wire [1:0] nq     = q + 2'd1;
  wire       is_ack = bcnt[3];
  wire       txbit  = txb[3'd7 - bcnt[2:0]];
  wire       tick   = (sym != SY_IDLE) && (dcnt == DLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym <= SY_IDLE;
      ph <= PH_AW;
      dcnt <= '0;
      q <= '0;
      bcnt <= '0;
      tries <= '0;
      sh <= '0;
      ra_l <= '0;
      wd_l <= '0;
      rd_l <= 1'b0;
      ack_ok <= 1'b0;
      rd_data <= '0;
      done <= 1'b0;
      err <= 1'b0;
      scl_drv_low <= 1'b0;
      sda_drv_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sym == SY_IDLE) begin
        dcnt <= '0;
        if (go) begin
          rd_l <= rd;
          ra_l <= reg_addr;
          wd_l <= wr_data;
          err <= 1'b0;
          tries <= '0;
          ph <= PH_AW;
          bcnt <= '0;
          q <= 2'd0;
          scl_drv_low <= 1'b1;
          sym <= SY_START;
        end
      end else if (!tick) begin
        dcnt <= dcnt + 1'b1;
      end else begin
        dcnt <= '0;
        q <= nq;
        unique case (nq)
          2'd0: begin
            unique case (sym)
              SY_START: begin
                sym <= SY_BIT;
                bcnt <= '0;
                scl_drv_low <= 1'b1;
              end
              SY_STOP: begin
                sym <= SY_IDLE;
                done <= 1'b1;
              end
              default: begin
                scl_drv_low <= 1'b1;
                if (!is_ack) begin
                  bcnt <= bcnt + 4'd1;
                end else if (ph == PH_RX) begin
                  rd_data <= sh;
                  sym <= SY_STOP;
                end else if (ack_ok) begin
                  tries <= '0;
                  bcnt <= '0;
                  unique case (ph)
                    PH_AW:  ph <= PH_REG;
                    PH_REG: if (rd_l) begin
                      ph <= PH_AR;
                      sym <= SY_START;
                    end else begin
                      ph <= PH_DAT;
                    end
                    PH_DAT: sym <= SY_STOP;
                    default: ph <= PH_RX;
                  endcase
                end else if (tries == TLAST) begin
                  err <= 1'b1;
                  sym <= SY_STOP;
                end else begin
                  tries <= tries + 1'b1;
                  bcnt <= '0;
                end
              end
            endcase
          end
          2'd1: sda_drv_low <= (sym == SY_STOP) ||
                               (sym == SY_BIT && ph != PH_RX && !is_ack && !txbit);
          2'd2: scl_drv_low <= 1'b0;
          default: begin
            unique case (sym)
              SY_START: sda_drv_low <= 1'b1;
              SY_STOP:  sda_drv_low <= 1'b0;
              default: begin
                if (is_ack) ack_ok <= !sda_in;
                else if (ph == PH_RX) sh <= {sh[6:0], sda_in};
              end
            endcase
          end
        endcase
      end
    end
  end
endmodule

module i2c_eeprom_master_chk #(
  parameter int QDIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic done,
  input logic err,
  input logic scl_drv_low,
  input logic sda_drv_low
);
  a_r1_no_joint_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drv_low != $past(scl_drv_low)) |-> (sda_drv_low == $past(sda_drv_low)));

  a_r1_sda_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drv_low) && QDIV > 1) |=> $stable(sda_drv_low));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_drv_low && !sda_drv_low));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !go) |=> err);
endmodule

bind i2c_eeprom_master i2c_eeprom_master_chk #(.QDIV(QDIV)) i_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .done(done), .err(err),
  .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low)
);

// File: tb/test_i2c_eeprom_master.sv
module test_i2c_eeprom_master;
  localparam int SIDLE = 0, SDEV = 1, SREG = 2, SWD = 3, SRD = 4;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, rd = 1'b0;
  logic [7:0] reg_addr = '0, wr_data = '0;
  logic [7:0] rd_data;
  logic done, err, scl_drv_low, sda_drv_low;
  logic s_drv = 1'b0;
  wire scl_line = ~scl_drv_low;
  wire sda_line = ~(sda_drv_low | s_drv);

  i2c_eeprom_master i_i2c_eeprom_master (
    .clk(clk), .rst_n(rst_n), .go(go), .rd(rd), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .done(done), .err(err),
    .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low), .sda_in(sda_line)
  );

  always #4 clk = ~clk;

  int nvec = 0, nfail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 7 + 3) ^ 8'h5A);
  endfunction

  // behavioural slave
  logic [7:0] smem [256];
  bit   [255:0] swr;
  int   s_st = SIDLE, s_bit = 0;
  logic [7:0] s_sh = '0, s_ptr = '0, s_tx = '0;
  logic s_rw = 1'b0, s_ack = 1'b0, s_mack = 1'b0;
  int   starts = 0, stops = 0, ndev = 0, regtries = 0, dattries = 0;
  logic [7:0] devlog [8];
  int   nack_st = SIDLE, nack_total = 0, nack_used = 0;
  int   last_rise = 0, scl_per = 0, joint = 0;
  logic p_scl = 1'b0, p_sda = 1'b0;

  function automatic logic [7:0] mval(input logic [7:0] a);
    return swr[a] ? smem[a] : init_val(int'(a));
  endfunction

  always @(posedge clk) begin
    if (rst_n && (scl_drv_low != p_scl) && (sda_drv_low != p_sda)) joint <= joint + 1;
    p_scl <= scl_drv_low;
    p_sda <= sda_drv_low;
  end

  always @(negedge sda_line) if (scl_line) begin
    starts = starts + 1;
    s_st = SDEV;
    s_bit = -1;
    s_drv = 1'b0;
  end

  always @(posedge sda_line) if (scl_line) begin
    stops = stops + 1;
    s_st = SIDLE;
    s_drv = 1'b0;
  end

  always @(posedge scl_line) begin
    scl_per = cyc - last_rise;
    last_rise = cyc;
    if (s_st != SIDLE && s_bit >= 0) begin
      if (s_bit < 8 && s_st != SRD) s_sh = {s_sh[6:0], sda_line};
      if (s_bit == 8 && s_st == SRD) s_mack = sda_line;
    end
  end

  always @(negedge scl_line) if (s_st != SIDLE) begin
    s_bit = s_bit + 1;
    if (s_bit == 8) begin
      if (s_st == SRD) s_drv = 1'b0;
      else begin
        s_ack = 1'b1;
        if (s_st == SDEV) begin
          devlog[ndev % 8] = s_sh;
          ndev = ndev + 1;
        end
        if (s_st == SREG) regtries = regtries + 1;
        if (s_st == SWD) dattries = dattries + 1;
        if (s_st == nack_st && nack_used < nack_total) begin
          s_ack = 1'b0;
          nack_used = nack_used + 1;
        end
        if (s_ack) begin
          if (s_st == SDEV) s_rw = s_sh[0];
          if (s_st == SREG) s_ptr = s_sh;
          if (s_st == SWD) begin
            smem[s_ptr] = s_sh;
            swr[s_ptr] = 1'b1;
            s_ptr = s_ptr + 8'd1;
          end
        end
        s_drv = s_ack;
      end
    end else if (s_bit == 9) begin
      s_drv = 1'b0;
      s_bit = 0;
      if (s_st == SRD) begin
        if (s_mack) s_st = SIDLE;
        else begin
          s_ptr = s_ptr + 8'd1;
          s_tx = mval(s_ptr);
          s_drv = ~s_tx[7];
        end
      end else if (s_ack) begin
        if (s_st == SDEV) begin
          if (s_rw) begin
            s_st = SRD;
            s_tx = mval(s_ptr);
            s_drv = ~s_tx[7];
          end else s_st = SREG;
        end else s_st = SWD;
      end
    end else if (s_st == SRD && s_bit >= 0 && s_bit < 8) begin
      s_drv = ~s_tx[3'(7 - s_bit)];
    end
  end

  // bench helpers
  logic [7:0] exp_mem [256];
  bit finished = 1'b0;

  task automatic chk(input string rq, input int act, input int expv);
    nvec++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  task automatic wait_done;
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 done seen", int'(done), 1);
    chk("R10 lines free", int'({scl_drv_low, sda_drv_low}), 0);
    @(negedge clk);
    chk("R10 one cycle", int'(done), 0);
  endtask

  task automatic txn(input bit r, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    go = 1'b1; rd = r; reg_addr = a; wr_data = d;
    @(negedge clk);
    go = 1'b0;
    wait_done();
  endtask

  task automatic good_txn(input bit r, input logic [7:0] a, input logic [7:0] d);
    int st0, sp0, nd0;
    st0 = starts; sp0 = stops; nd0 = ndev;
    txn(r, a, d);
    chk("R7 no err", int'(err), 0);
    chk("R2 starts", starts - st0, r ? 2 : 1);
    chk("R2 stops", stops - sp0, 1);
    if (r) begin
      chk("R5 read data", int'(rd_data), int'(exp_mem[a]));
      chk("R5 master nack", int'(s_mack), 1);
      chk("R3 addr+W", int'(devlog[nd0 % 8]), 8'hA0);
      chk("R3 addr+R", int'(devlog[(nd0 + 1) % 8]), 8'hA1);
    end else begin
      exp_mem[a] = d;
      chk("R4 slave holds byte", int'(mval(a)), int'(d));
      chk("R3 addr+W", int'(devlog[nd0 % 8]), 8'hA0);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int st0, sp0, rt0, dt0, nd0;
    seed = $urandom(32'h1C2E);
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset idle", int'({scl_drv_low, sda_drv_low, done, err}), 0);

    // directed write then read
    good_txn(1'b0, 8'h01, 8'h06);
    good_txn(1'b1, 8'h01, 8'h00);
    chk("R11 scl period", scl_per, 16);
    chk("R1 joint edges", joint, 0);
    good_txn(1'b1, 8'hFF, 8'h00);
    good_txn(1'b0, 8'h80, 8'hFF);
    good_txn(1'b1, 8'h80, 8'h00);

    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 15)) + 8'h20;
      good_txn(1'($urandom_range(0, 1)), a, 8'($urandom));
    end
    chk("R1 joint edges random", joint, 0);

    // R6: register byte refused once
    rt0 = regtries; nack_st = SREG; nack_total = nack_used + 1; st0 = starts;
    txn(1'b0, 8'h41, 8'h3C);
    exp_mem[8'h41] = 8'h3C;
    chk("R6 reg resent", regtries - rt0, 2);
    chk("R6 no new start", starts - st0, 1);
    chk("R6 err clear", int'(err), 0);
    chk("R6 data written", int'(mval(8'h41)), 8'h3C);

    // R6: address byte refused twice on a read
    nack_st = SDEV; nack_total = nack_used + 2; nd0 = ndev;
    txn(1'b1, 8'h41, 8'h00);
    chk("R6 dev resent count", ndev - nd0, 4);
    chk("R6 resent byte same", int'(devlog[(nd0 + 1) % 8]), 8'hA0);
    chk("R6 read ok", int'(rd_data), 8'h3C);
    chk("R6 edge limit no err", int'(err), 0);

    // R7: data byte refused three times
    dt0 = dattries; nack_st = SWD; nack_total = nack_used + 3; sp0 = stops;
    txn(1'b0, 8'h42, 8'hC3);
    chk("R7 three attempts", dattries - dt0, 3);
    chk("R7 err set", int'(err), 1);
    chk("R7 stop issued", stops - sp0, 1);
    chk("R7 slave unchanged", int'(mval(8'h42)), int'(exp_mem[8'h42]));
    repeat (50) @(negedge clk);
    chk("R8 err sticky", int'(err), 1);

    // R7: register byte refused three times in a read, no repeated start
    nack_st = SREG; nack_total = nack_used + 3; st0 = starts;
    txn(1'b1, 8'h42, 8'h00);
    chk("R7 read aborted err", int'(err), 1);
    chk("R7 no repeated start", starts - st0, 1);
    nack_st = SIDLE;

    // R8: next accepted go clears err
    @(negedge clk);
    go = 1'b1; rd = 1'b1; reg_addr = 8'h42;
    @(negedge clk);
    go = 1'b0;
    @(negedge clk);
    chk("R8 err cleared by go", int'(err), 0);
    wait_done();
    chk("R8 read after clear", int'(rd_data), int'(exp_mem[8'h42]));

    // R9: go while busy is ignored
    @(negedge clk);
    go = 1'b1; rd = 1'b0; reg_addr = 8'h50; wr_data = 8'hA5;
    @(negedge clk);
    go = 1'b0;
    repeat (200) @(negedge clk);
    go = 1'b1; reg_addr = 8'h51; wr_data = 8'h99;
    @(negedge clk);
    go = 1'b0;
    wait_done();
    exp_mem[8'h50] = 8'hA5;
    begin
      int extra = 0;
      for (int c = 0; c < 2000; c++) begin
        @(negedge clk);
        if (done || scl_drv_low) extra++;
      end
      chk("R9 no second txn", extra, 0);
    end
    chk("R9 latched byte written", int'(mval(8'h50)), 8'hA5);
    chk("R9 other addr untouched", int'(mval(8'h51)), int'(exp_mem[8'h51]));
    chk("R1 joint edges final", joint, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule